// File: doc/BRIEF.md
# Password-Gated Sector Memory Slave

This block is the slave end of a two-wire serial memory. The storage is a flat byte array cut into fixed sectors of eight bytes, thirty of them by default. A master opens a transaction with a start condition and sends a command byte that names the direction and the sector. It then sends an eight-byte key and one extra poll byte. The slave acknowledges the poll byte only if the key matched the stored key for that direction and the sector exists. Data moves only after that acknowledge.

Reads begin at the first byte of the sector and run on through the array for as long as the master keeps acknowledging. Writes take exactly one sector's worth of bytes into a staging buffer. A stop then starts a timed nonvolatile commit, shown on a busy output. Any wrong key, bad sector, early stop or surplus byte sends the slave back to standby with the array untouched.

The bus lines are sampled by the system clock. SDA is modelled as an open-drain pull-down enable. SCL must stay high and low for at least four system clocks each.

Top module: `secmem_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) opens a transaction and a stop (SDA rising while SCL is high) ends it. `sda_oe` only rises while SCL is low, and it is low on the cycle after a stop is seen.
- R2: The first byte after a start is the command: bit 7 = 1 selects write and 0 selects read, bits 4:0 hold the sector number, and bits 6:5 are ignored. It is acknowledged when no commit is running.
- R3: A command byte that arrives while a commit is running is not acknowledged, and the slave returns to standby.
- R4: The eight bytes after the command are the key, each acknowledged. The first key byte is compared with key bits 63:56 and the last with bits 7:0. Reads are checked against `READ_KEY` and writes against `WRITE_KEY`.
- R5: The tenth byte is the poll byte; its value is ignored. It is acknowledged only if all key bytes matched and the sector number is below `SECTORS`. Otherwise it is not acknowledged, and the slave neither drives SDA nor moves data until the next start.
- R6: A read sends bytes MSB first, starting at address sector×8. The address increments after each master acknowledge and wraps from the last array byte to 0. A master no-acknowledge ends the read and the slave releases SDA.
- R7: A write acknowledges eight data bytes. After the following stop they are stored, in order, at bytes 0 to 7 of the sector.
- R8: A stop before the eighth data byte, or a ninth data byte (which is not acknowledged), abandons the write: no commit starts and the array is unchanged.
- R9: `nv_busy` rises on the cycle after the stop that ends a complete write and stays high for exactly `WR_CYCLES` clocks. The new data is readable after it falls.
- R10: After reset `sda_oe` and `nv_busy` are low and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Level of the shared data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| nv_busy | output | 1 | Nonvolatile commit in progress |

## Verification
The slave captures each bit two system clocks after the SCL rising edge. It settles its acknowledge or data drive two clocks after the SCL falling edge. The bench therefore changes SDA only while SCL is low, holds each SCL phase for four clocks, and reads the line halfway through the SCL high phase. `nv_busy` is due one clock after the stop is seen. A monitor samples it on every falling clock edge and compares each busy run with `WR_CYCLES`. Array contents are checked by reading them back through later transactions, against a byte model kept in the bench.

// File: rtl/secmem_pkg.sv
// Shared types for the password-gated sector memory slave.
// Assumes: nothing beyond standard SystemVerilog.
package secmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // standby, line released
        ST_CMD,    // receiving the command byte
        ST_KEY,    // receiving key bytes
        ST_POLL,   // receiving the acknowledge-poll byte
        ST_WR,     // receiving write data
        ST_RD      // sending read data
    } txn_state_t;
endpackage

// File: rtl/secmem_line_sense.sv
// Samples the two bus lines and flags SCL edges plus start and stop
// conditions. Assumes the lines are already free of metastability and
// change far slower than clk.
module secmem_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic scl_q, scl_qq, sda_q, sda_qq;

    // two-stage history of both lines, idle-high after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            scl_qq <= 1'b1;
            sda_q  <= 1'b1;
            sda_qq <= 1'b1;
        end else begin
            scl_q  <= scl;
            scl_qq <= scl_q;
            sda_q  <= sda;
            sda_qq <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_qq;
    assign scl_fall  = ~scl_q & scl_qq;
    assign start_det = scl_q & scl_qq & sda_qq & ~sda_q;
    assign stop_det  = scl_q & scl_qq & ~sda_qq & sda_q;
    assign sda_bit   = sda_q;
endmodule

// File: rtl/secmem_bit_engine.sv
// Counts the nine clocks of each byte frame. Shifts received bits in on
// SCL rising edges and updates the open-drain enable on SCL falling edges:
// data bits when transmitting, the acknowledge in the ninth slot when
// receiving. Assumes SCL high and low phases of at least four clk cycles,
// so that the controller has settled before each falling edge.
module secmem_bit_engine
    import secmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              frame_clr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    input  logic              tx_mode,
    input  logic              ack_drive,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              slot_done,
    output logic              master_ack,
    output logic              sda_oe
);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

    logic [3:0] bitcnt;

    // bit position within the frame and the receive shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            rx_byte <= '0;
        end else if (frame_clr || !active) begin
            bitcnt <= '0;
        end else if (scl_rise) begin
            if (bitcnt == ACK_SLOT) begin
                bitcnt <= '0;
            end else begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda_bit};
                bitcnt  <= bitcnt + 4'd1;
            end
        end
    end

    // one-cycle markers for byte complete and ninth slot complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_done  <= 1'b0;
            slot_done  <= 1'b0;
            master_ack <= 1'b0;
        end else begin
            byte_done <= active && !frame_clr && scl_rise && (bitcnt == ACK_SLOT - 4'd1);
            slot_done <= active && !frame_clr && scl_rise && (bitcnt == ACK_SLOT);
            if (active && scl_rise && (bitcnt == ACK_SLOT))
                master_ack <= ~sda_bit;
        end
    end

    // open-drain enable, changed only on SCL falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || frame_clr || !active) begin
            sda_oe <= 1'b0;
        end else if (scl_fall) begin
            if (bitcnt == ACK_SLOT)
                sda_oe <= ack_drive & ~tx_mode;
            else if (tx_mode)
                sda_oe <= ~tx_byte[3'(4'd7 - bitcnt)];
            else
                sda_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/secmem_txn_ctrl.sv
// Transaction sequencer: command, key, acknowledge poll, then data.
// Decides each acknowledge, collects the write staging bytes, steps the
// read address and requests a commit on a stop after a full write.
// Assumes the bit engine reports byte_done and slot_done as single pulses.
module secmem_txn_ctrl
    import secmem_pkg::*;
#(
    parameter int                      SECTORS    = 30,
    parameter int                      SECT_BYTES = 8,
    parameter int                      KEY_BYTES  = 8,
    parameter logic [KEY_BYTES*8-1:0]  READ_KEY   = '0,
    parameter logic [KEY_BYTES*8-1:0]  WRITE_KEY  = '0,
    localparam int TOTAL  = SECTORS * SECT_BYTES,
    localparam int ADDR_W = $clog2(TOTAL),
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int IDX_W  = $clog2(SECT_BYTES),
    localparam int CNT_W  = $clog2(SECT_BYTES + 1),
    localparam int KI_W   = $clog2(KEY_BYTES + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_det,
    input  logic                         stop_det,
    input  logic                         byte_done,
    input  logic                         slot_done,
    input  logic                         master_ack,
    input  logic [BYTE_W-1:0]            rx_byte,
    input  logic                         nv_busy,
    output logic                         active,
    output logic                         tx_mode,
    output logic                         ack_drive,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic                         wr_go,
    output logic [SEC_W-1:0]             wr_sector,
    output logic [SECT_BYTES*BYTE_W-1:0] wr_data
);
    txn_state_t        state;
    logic              is_write;
    logic [SEC_W-1:0]  sector;
    logic [KI_W-1:0]   key_idx;
    logic              key_bad;
    logic [CNT_W-1:0]  wcnt;
    logic [BYTE_W-1:0] stage [SECT_BYTES];

    // key byte expected at position idx, most significant byte first
    function automatic logic [BYTE_W-1:0] key_byte(input logic [KEY_BYTES*8-1:0] k,
                                                   input int idx);
        return k[(KEY_BYTES-1-idx)*BYTE_W +: BYTE_W];
    endfunction

    logic [BYTE_W-1:0] key_expect;
    logic              poll_ok;

    // compare value for the current key byte and the poll verdict
    always_comb begin
        key_expect = is_write ? key_byte(WRITE_KEY, int'(key_idx))
                              : key_byte(READ_KEY, int'(key_idx));
        poll_ok    = !key_bad && (int'(sector) < SECTORS);
    end

    // transaction sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            is_write  <= 1'b0;
            sector    <= '0;
            key_idx   <= '0;
            key_bad   <= 1'b0;
            wcnt      <= '0;
            ack_drive <= 1'b0;
            rd_addr   <= '0;
        end else if (start_det) begin
            state     <= ST_CMD;
            key_idx   <= '0;
            key_bad   <= 1'b0;
            wcnt      <= '0;
            ack_drive <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            ack_drive <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (byte_done) begin
                        is_write <= rx_byte[BYTE_W-1];
                        sector   <= rx_byte[SEC_W-1:0];
                        if (nv_busy) begin
                            state     <= ST_IDLE;
                            ack_drive <= 1'b0;
                        end else begin
                            ack_drive <= 1'b1;
                        end
                    end else if (slot_done) begin
                        ack_drive <= 1'b0;
                        state     <= ST_KEY;
                    end
                end
                ST_KEY: begin
                    if (byte_done) begin
                        if (rx_byte != key_expect)
                            key_bad <= 1'b1;
                        key_idx   <= key_idx + 1'b1;
                        ack_drive <= 1'b1;
                    end else if (slot_done) begin
                        ack_drive <= 1'b0;
                        if (key_idx == KI_W'(KEY_BYTES))
                            state <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (byte_done) begin
                        if (poll_ok) begin
                            ack_drive <= 1'b1;
                        end else begin
                            ack_drive <= 1'b0;
                            state     <= ST_IDLE;
                        end
                    end else if (slot_done) begin
                        ack_drive <= 1'b0;
                        if (is_write) begin
                            state <= ST_WR;
                            wcnt  <= '0;
                        end else begin
                            state   <= ST_RD;
                            rd_addr <= ADDR_W'(int'(sector) * SECT_BYTES);
                        end
                    end
                end
                ST_WR: begin
                    if (byte_done) begin
                        if (wcnt < CNT_W'(SECT_BYTES)) begin
                            wcnt      <= wcnt + 1'b1;
                            ack_drive <= 1'b1;
                        end else begin
                            ack_drive <= 1'b0;
                            state     <= ST_IDLE;
                        end
                    end else if (slot_done) begin
                        ack_drive <= 1'b0;
                    end
                end
                ST_RD: begin
                    if (slot_done) begin
                        if (master_ack)
                            rd_addr <= (rd_addr == ADDR_W'(TOTAL - 1)) ? '0 : rd_addr + 1'b1;
                        else
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // staging buffer for write data, filled in arrival order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SECT_BYTES; i++)
                stage[i] <= '0;
        end else if (state == ST_WR && byte_done && !start_det && !stop_det
                     && wcnt < CNT_W'(SECT_BYTES)) begin
            stage[wcnt[IDX_W-1:0]] <= rx_byte;
        end
    end

    for (genvar g = 0; g < SECT_BYTES; g++) begin : g_pack
        assign wr_data[g*BYTE_W +: BYTE_W] = stage[g];
    end

    assign active    = (state != ST_IDLE);
    assign tx_mode   = (state == ST_RD);
    assign wr_go     = stop_det && (state == ST_WR) && (wcnt == CNT_W'(SECT_BYTES));
    assign wr_sector = sector;
endmodule

// File: rtl/secmem_store.sv
// Byte array standing in for the nonvolatile cells. A commit request
// latches one sector of staged data, holds busy for WR_CYCLES clocks and
// then writes all bytes of the sector at once. Assumes WR_CYCLES >= 2 and
// that no request arrives while busy.
module secmem_store
    import secmem_pkg::*;
#(
    parameter int SECTORS    = 30,
    parameter int SECT_BYTES = 8,
    parameter int WR_CYCLES  = 200,
    localparam int TOTAL  = SECTORS * SECT_BYTES,
    localparam int ADDR_W = $clog2(TOTAL),
    localparam int SEC_W  = $clog2(SECTORS),
    localparam int TMR_W  = $clog2(WR_CYCLES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         wr_go,
    input  logic [SEC_W-1:0]             wr_sector,
    input  logic [SECT_BYTES*BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0]            rd_data,
    output logic                         nv_busy
);
    logic [BYTE_W-1:0]            cells [TOTAL];
    logic [SECT_BYTES*BYTE_W-1:0] pend_data;
    logic [SEC_W-1:0]             pend_sector;
    logic [TMR_W-1:0]             tmr;

    // commit timer, pending sector capture and delayed cell update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_busy     <= 1'b0;
            tmr         <= '0;
            pend_data   <= '0;
            pend_sector <= '0;
            for (int i = 0; i < TOTAL; i++)
                cells[i] <= '0;
        end else if (nv_busy) begin
            if (tmr == TMR_W'(WR_CYCLES - 1)) begin
                nv_busy <= 1'b0;
                for (int i = 0; i < SECT_BYTES; i++)
                    cells[ADDR_W'(int'(pend_sector) * SECT_BYTES + i)]
                        <= pend_data[i*BYTE_W +: BYTE_W];
            end else begin
                tmr <= tmr + 1'b1;
            end
        end else if (wr_go) begin
            nv_busy     <= 1'b1;
            tmr         <= '0;
            pend_data   <= wr_data;
            pend_sector <= wr_sector;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/secmem_slave.sv
// Top of the password-gated sector memory slave. Joins line sensing, the
// bit engine, the transaction sequencer and the storage array.
// Assumes sda_in is the resolved level of the shared open-drain line.
module secmem_slave
    import secmem_pkg::*;
#(
    parameter int                     SECTORS    = 30,
    parameter int                     SECT_BYTES = 8,
    parameter int                     KEY_BYTES  = 8,
    parameter int                     WR_CYCLES  = 200,
    parameter logic [KEY_BYTES*8-1:0] READ_KEY   = '0,
    parameter logic [KEY_BYTES*8-1:0] WRITE_KEY  = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    output logic sda_oe,
    output logic nv_busy
);
    localparam int TOTAL  = SECTORS * SECT_BYTES;
    localparam int ADDR_W = $clog2(TOTAL);
    localparam int SEC_W  = $clog2(SECTORS);

    logic                         scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic                         active, tx_mode, ack_drive;
    logic                         byte_done, slot_done, master_ack;
    logic [BYTE_W-1:0]            rx_byte, rd_data;
    logic [ADDR_W-1:0]            rd_addr;
    logic                         wr_go;
    logic [SEC_W-1:0]             wr_sector;
    logic [SECT_BYTES*BYTE_W-1:0] wr_data;

    secmem_line_sense u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl),
        .sda       (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    secmem_bit_engine u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .frame_clr  (start_det | stop_det),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_bit    (sda_bit),
        .tx_mode    (tx_mode),
        .ack_drive  (ack_drive),
        .tx_byte    (rd_data),
        .rx_byte    (rx_byte),
        .byte_done  (byte_done),
        .slot_done  (slot_done),
        .master_ack (master_ack),
        .sda_oe     (sda_oe)
    );

    secmem_txn_ctrl #(
        .SECTORS    (SECTORS),
        .SECT_BYTES (SECT_BYTES),
        .KEY_BYTES  (KEY_BYTES),
        .READ_KEY   (READ_KEY),
        .WRITE_KEY  (WRITE_KEY)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .byte_done  (byte_done),
        .slot_done  (slot_done),
        .master_ack (master_ack),
        .rx_byte    (rx_byte),
        .nv_busy    (nv_busy),
        .active     (active),
        .tx_mode    (tx_mode),
        .ack_drive  (ack_drive),
        .rd_addr    (rd_addr),
        .wr_go      (wr_go),
        .wr_sector  (wr_sector),
        .wr_data    (wr_data)
    );

    secmem_store #(
        .SECTORS    (SECTORS),
        .SECT_BYTES (SECT_BYTES),
        .WR_CYCLES  (WR_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .wr_go     (wr_go),
        .wr_sector (wr_sector),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .nv_busy   (nv_busy)
    );
endmodule

// File: rtl/secmem_slave_chk.sv
// Property checker for secmem_slave, attached with bind below.
// Assumes it sees the top ports plus the internal stop and commit pulses.
module secmem_slave_chk #(
    parameter int WR_CYCLES = 200
) (
    input logic clk,
    input logic rst_n,
    input logic scl,
    input logic sda_oe,
    input logic nv_busy,
    input logic stop_det,
    input logic wr_go
);
    int busy_run;

    // length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= nv_busy ? busy_run + 1 : 0;
    end

    // R1
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> !$rose(sda_oe));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(wr_go) && $past(stop_det));

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_busy) |-> busy_run == WR_CYCLES);
endmodule

bind secmem_slave secmem_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl),
    .sda_oe   (sda_oe),
    .nv_busy  (nv_busy),
    .stop_det (stop_det),
    .wr_go    (wr_go)
);

// File: tb/secmem_slave_test.sv
`timescale 1ns/1ps
module secmem_slave_test;
    localparam int          H     = 4;
    localparam int          W     = 200;
    localparam int          NSEC  = 30;
    localparam int          TOT   = NSEC * 8;
    localparam logic [63:0] RKEY  = 64'h1122_3344_5566_7788;
    localparam logic [63:0] WKEY  = 64'hA5C3_0F96_5A3C_F069;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, nv_busy;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;
    int busy_cnt = 0;
    int last_run = 0;
    logic [7:0] model [TOT];

    always #2 clk = ~clk;

    secmem_slave #(
        .SECTORS(NSEC), .SECT_BYTES(8), .KEY_BYTES(8), .WR_CYCLES(W),
        .READ_KEY(RKEY), .WRITE_KEY(WKEY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .nv_busy(nv_busy)
    );

    // busy run length monitor
    always @(negedge clk) begin
        if (nv_busy) busy_cnt <= busy_cnt + 1;
        else if (busy_cnt != 0) begin
            last_run <= busy_cnt;
            busy_cnt <= 0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_clk(H);
        scl_m = 1'b1; wait_clk(H);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_clk(H);
        scl_m = 1'b1; wait_clk(H / 2);
        b = sda_line; wait_clk(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = (b == 1'b0);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    task automatic head(input logic [7:0] cmd, input logic [63:0] key,
                        output bit cmd_ack, output int key_acks, output bit poll_ack);
        bit a;
        bus_start;
        send_byte(cmd, cmd_ack);
        key_acks = 0;
        for (int i = 0; i < 8; i++) begin
            send_byte(key[63 - 8*i -: 8], a);
            key_acks += int'(a);
        end
        send_byte(8'h5A, poll_ack);
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 37 + i * 11 + 5) & 255);
    endfunction

    // full read of n bytes starting at sector s, compared with the model
    task automatic do_read(input int s, input int n, input string req);
        bit ca, pa;
        int ka;
        logic [7:0] v;
        head(8'(s), RKEY, ca, ka, pa);
        chk("R2 read command ack", 64'(ca), 64'd1);
        chk("R4 read key acks", 64'(ka), 64'd8);
        chk("R5 read poll ack", 64'(pa), 64'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(req, 64'(v), 64'(model[(s * 8 + k) % TOT]));
        end
        bus_stop;
    endtask

    // complete eight-byte write with pattern, then wait for commit
    task automatic do_write(input int s);
        bit ca, pa, a;
        int ka, da;
        head(8'h80 | 8'((s & 3) << 5) | 8'(s), WKEY, ca, ka, pa);
        chk("R2 write command ack (bits 6:5 ignored)", 64'(ca), 64'd1);
        chk("R4 write key acks", 64'(ka), 64'd8);
        chk("R5 write poll ack", 64'(pa), 64'd1);
        da = 0;
        for (int i = 0; i < 8; i++) begin
            send_byte(pat(s, i), a);
            da += int'(a);
            model[s * 8 + i] = pat(s, i);
        end
        chk("R7 write data acks", 64'(da), 64'd8);
        bus_stop;
        chk("R9 busy after stop", 64'(nv_busy), 64'd1);
        chk("R1 line released after stop", 64'(sda_oe), 64'd0);
        if (s == 0) begin
            bus_start;
            send_byte(8'h01, a);
            chk("R3 command during commit not acked", 64'(a), 64'd0);
            bus_stop;
        end
        while (nv_busy) wait_clk(1);
        wait_clk(2);
        chk("R9 busy length", 64'(last_run), 64'(W));
    endtask

    initial begin
        bit ca, pa, a;
        int ka;
        logic [7:0] v;
        for (int i = 0; i < TOT; i++) model[i] = 8'h00;
        wait_clk(5);
        chk("R10 sda_oe after reset", 64'(sda_oe), 64'd0);
        chk("R10 nv_busy after reset", 64'(nv_busy), 64'd0);
        rst_n = 1'b1;
        wait_clk(5);

        do_read(3, 8, "R10 array zero after reset");

        for (int s = 0; s < NSEC; s++) do_write(s);
        for (int s = 0; s < NSEC; s++) do_read(s, 8, "R6 sector read data");
        do_read(29, 16, "R6 read wraps past last byte");
        do_read(5, 20, "R6 read continues across sectors");

        // wrong read key: last key byte altered
        head(8'h04, RKEY ^ 64'h1, ca, ka, pa);
        chk("R4 wrong key bytes still acked", 64'(ka), 64'd8);
        chk("R5 poll not acked on wrong key", 64'(pa), 64'd0);
        recv_byte(1'b0, v);
        chk("R5 no data after failed poll", 64'(v), 64'hFF);
        bus_stop;

        // read with the write key
        head(8'h04, WKEY, ca, ka, pa);
        chk("R4 read rejects write key", 64'(pa), 64'd0);
        bus_stop;

        // write with the read key, must leave sector 9 alone
        head(8'h89, RKEY, ca, ka, pa);
        chk("R4 write rejects read key", 64'(pa), 64'd0);
        for (int i = 0; i < 8; i++) send_byte(8'h00, a);
        bus_stop;
        wait_clk(4);
        chk("R4 no commit on wrong write key", 64'(nv_busy), 64'd0);

        // sector numbers past the end
        head(8'h1E, RKEY, ca, ka, pa);
        chk("R5 sector 30 poll not acked", 64'(pa), 64'd0);
        bus_stop;
        head(8'h1F, RKEY, ca, ka, pa);
        chk("R5 sector 31 poll not acked", 64'(pa), 64'd0);
        bus_stop;

        // short write: five bytes then stop
        head(8'h87, WKEY, ca, ka, pa);
        chk("R5 poll ack before short write", 64'(pa), 64'd1);
        for (int i = 0; i < 5; i++) send_byte(8'hEE, a);
        bus_stop;
        wait_clk(4);
        chk("R8 short write starts no commit", 64'(nv_busy), 64'd0);

        // long write: ninth byte refused
        head(8'h88, WKEY, ca, ka, pa);
        for (int i = 0; i < 8; i++) send_byte(8'hDD, a);
        send_byte(8'hDD, a);
        chk("R8 ninth write byte not acked", 64'(a), 64'd0);
        bus_stop;
        wait_clk(4);
        chk("R8 long write starts no commit", 64'(nv_busy), 64'd0);

        // stop in the middle of the key, then a clean transaction
        bus_start;
        send_byte(8'h02, a);
        for (int i = 0; i < 4; i++) send_byte(RKEY[63 - 8*i -: 8], a);
        bus_stop;
        chk("R1 released after mid-key stop", 64'(sda_oe), 64'd0);

        do_read(7, 8, "R8 sector 7 unchanged after short write");
        do_read(8, 8, "R8 sector 8 unchanged after long write");
        do_read(9, 8, "R4 sector 9 unchanged after wrong key write");
        do_read(2, 8, "R1 transaction after aborted one");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule